// File: doc/BRIEF.md
# Modulus Reload Timer Counter

This block is a 16-bit upward counter with a 16-bit modulus latch beside it. The count does not wrap to zero. When it rolls past its all-ones value, or when a chosen transition appears on an external load pin, the counter is refilled from the latch. The count period is therefore set by the latch value rather than fixed at 65536 steps.

Software reaches the block through a small register port. A write to the count register fills the counter and the latch in the same cycle, and counting resumes upward from the written value. The counter only steps on cycles where a global run enable is high and the prescaler tap picked by the control register is pulsing. The counter can be placed on one of several time-base bus outputs. A rollover sets a sticky flag, which raises an interrupt request when the matching enable bit is set.

Top module: `modulus_timer`

## Requirements
- R1: After reset the control register, counter, modulus latch, interrupt request and every time-base bus output are all zero.
- R2: The counter steps up by exactly one on each clock where `run_en` is high and the tap `tick_i[ctrl[1:0]]` is high. On any other clock it holds its value, unless a load or write applies.
- R3: On a counted clock with the counter at 0xFFFF, the counter takes the modulus latch value instead of 0x0000, and the overflow flag (control bit 15) is set.
- R4: A write to address 1 puts the written value into both the counter and the modulus latch on the same clock. The latch reads back at address 2, and writes to address 2 change nothing.
- R5: Control bits [3:2] choose which edge of `load_pin` loads the counter from the latch: 00 none, 01 rising, 10 falling, 11 both. The pin is synchronized, so the load appears on the third rising clock edge after the pin changes.
- R6: When a load-pin edge and an overflow land on the same clock, one reload from the latch results and the flag is set. A count-register write on that clock overrides both.
- R7: Writing 1 to control bit 15 clears the flag, and writing 0 leaves it unchanged. `irq` is high exactly when the flag and control bit 6 (interrupt enable) are both set.
- R8: Control bit 5 enables time-base drive and bit 4 picks the bus. The selected 16-bit slice of `tbus_o` (bus n at bits [16n+15:16n]) carries the counter, and every other slice is zero.
- R9: Control bits [14:7] and address 3 read as zero. Writes to those bits or to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global prescaler-run enable |
| tick_i | input | 4 | Prescaler tap pulses, one per selectable clock source |
| load_pin | input | 1 | External asynchronous modulus-load input |
| reg_addr | input | 2 | Register address: 0 control, 1 counter, 2 latch, 3 reserved |
| reg_wdata | input | 16 | Register write data |
| reg_wr | input | 1 | Register write strobe, sampled on the clock edge |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| tbus_o | output | 32 | Time-base buses, 16 bits each |

## Verification
Register writes, counted ticks, overflow reloads and the flag all take effect at the first rising edge after the stimulus, and the read port is combinational. The bench therefore samples at the next falling edge. A load-pin edge passes through two synchronizer stages and one edge-history stage, so its reload is due at the third rising edge. The bench checks that the old count is still present after the second edge and that the reload has happened after the third. The collision cases line up a tick or a write with exactly that third edge, so that each collision happens on a known cycle.

// File: rtl/modt_pkg.sv
package modt_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned ADDR_W    = 2;
  localparam logic [1:0]  ADDR_CTRL = 2'd0;
  localparam logic [1:0]  ADDR_CNT  = 2'd1;
  localparam logic [1:0]  ADDR_MOD  = 2'd2;

endpackage

// File: rtl/modt_edge.sv
module modt_edge
  import modt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  edge_sel_e edge_sel,
  output logic      load_evt
);

  localparam int unsigned HIST_W = SYNC_STAGES + 1;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;
  logic              rise;
  logic              fall;

  always_comb begin
    hist_d = {hist_q[HIST_W-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_comb begin
    rise = hist_q[HIST_W-2] & ~hist_q[HIST_W-1];
    fall = ~hist_q[HIST_W-2] & hist_q[HIST_W-1];
    unique case (edge_sel)
      EDGE_RISE: load_evt = rise;
      EDGE_FALL: load_evt = fall;
      EDGE_BOTH: load_evt = rise | fall;
      default:   load_evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/modt_regs.sv
module modt_regs
  import modt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CS_W   = 2,
  parameter int unsigned BS_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf_evt,
  output logic [CS_W-1:0]   clk_sel,
  output edge_sel_e         edge_sel,
  output logic [BS_W-1:0]   bus_sel,
  output logic              bus_en,
  output logic              irq_en,
  output logic              flag,
  output logic              irq
);

  localparam int unsigned ES_LSB   = CS_W;
  localparam int unsigned BS_LSB   = ES_LSB + 2;
  localparam int unsigned BE_BIT   = BS_LSB + BS_W;
  localparam int unsigned IE_BIT   = BE_BIT + 1;
  localparam int unsigned FLAG_BIT = DATA_W - 1;
  localparam int unsigned CFG_W    = IE_BIT + 1;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             flag_q, flag_d;
  logic             ctrl_wr;

  always_comb begin
    ctrl_wr = wr_en && (addr == ADDR_CTRL);
    cfg_d   = cfg_q;
    if (ctrl_wr) cfg_d = wdata[CFG_W-1:0];
    flag_d = flag_q;
    if (ctrl_wr && wdata[FLAG_BIT]) flag_d = 1'b0;
    if (ovf_evt)                    flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    clk_sel  = cfg_q[CS_W-1:0];
    edge_sel = edge_sel_e'(cfg_q[ES_LSB +: 2]);
    bus_sel  = cfg_q[BS_LSB +: BS_W];
    bus_en   = cfg_q[BE_BIT];
    irq_en   = cfg_q[IE_BIT];
    flag     = flag_q;
    irq      = flag_q & cfg_q[IE_BIT];
  end

endmodule

// File: rtl/modt_counter.sv
module modt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load_evt,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] latch_o,
  output logic             ovf_evt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lat_q, lat_d;
  logic             at_top;

  always_comb begin
    at_top  = &cnt_q;
    ovf_evt = adv && at_top && !wr_cnt;
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    if (wr_cnt) begin
      cnt_d = wdata;
      lat_d = wdata;
    end else if (load_evt || ovf_evt) begin
      cnt_d = lat_q;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign latch_o = lat_q;

endmodule

// File: rtl/modt_tbus.sv
module modt_tbus #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned NUM_BUSES = 2,
  parameter int unsigned BS_W      = 1
) (
  input  logic [CNT_W-1:0]           cnt,
  input  logic                       bus_en,
  input  logic [BS_W-1:0]            bus_sel,
  output logic [NUM_BUSES*CNT_W-1:0] tbus
);

  for (genvar b = 0; b < NUM_BUSES; b++) begin : g_bus
    always_comb begin
      if (bus_en && (bus_sel == BS_W'(b))) tbus[b*CNT_W +: CNT_W] = cnt;
      else                                 tbus[b*CNT_W +: CNT_W] = '0;
    end
  end

endmodule

// File: rtl/modulus_timer.sv
module modulus_timer
  import modt_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned NUM_TAPS  = 4,
  parameter int unsigned NUM_BUSES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_en,
  input  logic [NUM_TAPS-1:0]        tick_i,
  input  logic                       load_pin,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [CNT_W-1:0]           reg_wdata,
  input  logic                       reg_wr,
  output logic [CNT_W-1:0]           reg_rdata,
  output logic                       irq,
  output logic [NUM_BUSES*CNT_W-1:0] tbus_o
);

  localparam int unsigned CS_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;
  localparam int unsigned BS_W   = (NUM_BUSES > 1) ? $clog2(NUM_BUSES) : 1;
  localparam int unsigned CFG_W  = CS_W + 2 + BS_W + 2;
  localparam int unsigned PAD_W  = CNT_W - 1 - CFG_W;

  logic [CS_W-1:0]  clk_sel;
  edge_sel_e        edge_sel;
  logic [BS_W-1:0]  bus_sel;
  logic             bus_en;
  logic             irq_en;
  logic             flag_q;
  logic             adv;
  logic             load_evt;
  logic             cnt_wr;
  logic             ovf_evt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] latch_q;

  always_comb begin
    adv    = run_en && tick_i[clk_sel];
    cnt_wr = reg_wr && (reg_addr == ADDR_CNT);
  end

  modt_regs #(.DATA_W(CNT_W), .CS_W(CS_W), .BS_W(BS_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .ovf_evt  (ovf_evt),
    .clk_sel  (clk_sel),
    .edge_sel (edge_sel),
    .bus_sel  (bus_sel),
    .bus_en   (bus_en),
    .irq_en   (irq_en),
    .flag     (flag_q),
    .irq      (irq)
  );

  modt_edge #(.SYNC_STAGES(2)) edge_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (load_pin),
    .edge_sel (edge_sel),
    .load_evt (load_evt)
  );

  modt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .load_evt (load_evt),
    .wr_cnt   (cnt_wr),
    .wdata    (reg_wdata),
    .cnt_o    (cnt_q),
    .latch_o  (latch_q),
    .ovf_evt  (ovf_evt)
  );

  modt_tbus #(.CNT_W(CNT_W), .NUM_BUSES(NUM_BUSES), .BS_W(BS_W)) tbus_i (
    .cnt     (cnt_q),
    .bus_en  (bus_en),
    .bus_sel (bus_sel),
    .tbus    (tbus_o)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = {flag_q, {PAD_W{1'b0}}, irq_en, bus_en, bus_sel,
                              2'(edge_sel), clk_sel};
      ADDR_CNT:  reg_rdata = cnt_q;
      ADDR_MOD:  reg_rdata = latch_q;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/modt_checker.sv
module modt_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv,
  input logic             load_evt,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] latch_q,
  input logic             flag_q,
  input logic             irq
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load_evt && !cnt_wr && !(&cnt_q)) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load_evt && !cnt_wr) |=> $stable(cnt_q)); // R2

  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (&cnt_q) && !cnt_wr) |=> (cnt_q == $past(latch_q)) && flag_q); // R3

  AST_WRITE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wdata)) && (latch_q == $past(wdata))); // R4

  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> $stable(latch_q)); // R4

  AST_EDGE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !cnt_wr) |=> cnt_q == $past(latch_q)); // R5

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q); // R7

endmodule

bind modulus_timer modt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .adv      (adv),
  .load_evt (load_evt),
  .cnt_wr   (cnt_wr),
  .wdata    (reg_wdata),
  .cnt_q    (cnt_q),
  .latch_q  (latch_q),
  .flag_q   (flag_q),
  .irq      (irq)
);

// File: tb/modulus_timer_tb_top.sv
module modulus_timer_tb_top;

  localparam int KIND_REG  = 0;
  localparam int KIND_IRQ  = 1;
  localparam int KIND_TBUS = 2;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  logic        clk;
  logic        rst_n;
  logic        run_en;
  logic [3:0]  tick_i;
  logic        load_pin;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_wr;
  logic [15:0] reg_rdata;
  logic        irq;
  logic [31:0] tbus_o;

  exp_item_t exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  modulus_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .tick_i    (tick_i),
    .load_pin  (load_pin),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .tbus_o    (tbus_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: pops expected items and compares against the design outputs
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      #1;
      begin
        exp_item_t it;
        logic [31:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          KIND_REG: act = {16'h0, reg_rdata};
          KIND_IRQ: act = {31'h0, irq};
          default:  act = tbus_o;
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push_exp(input int kind, input logic [1:0] a, input logic [31:0] e,
                          input string tag);
    exp_item_t it;
    reg_addr = a;
    it.kind = kind;
    it.exp  = e;
    it.tag  = tag;
    exp_q.push_back(it);
    #2;
  endtask

  task automatic chk_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
    push_exp(KIND_REG, a, {16'h0, e}, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic ticks(input int n, input logic [3:0] mask);
    for (int i = 0; i < n; i++) begin
      tick_i = mask;
      @(negedge clk);
    end
    tick_i = 4'h0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; tick_i = 4'h0; load_pin = 1'b0;
    reg_addr = 2'd0; reg_wdata = 16'h0; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_reg(2'd0, 16'h0000, "R1 ctrl");
    chk_reg(2'd1, 16'h0000, "R1 counter");
    chk_reg(2'd2, 16'h0000, "R1 latch");
    push_exp(KIND_IRQ, 2'd0, 32'h0, "R1 irq");
    push_exp(KIND_TBUS, 2'd0, 32'h0, "R1 tbus");

    // R2 no stepping without run enable; R4 write fills both
    wr(2'd1, 16'h0010);
    tick_i = 4'hF;
    repeat (3) @(negedge clk);
    tick_i = 4'h0;
    chk_reg(2'd1, 16'h0010, "R2 hold without run");
    chk_reg(2'd2, 16'h0010, "R4 latch loaded");

    run_en = 1'b1;
    ticks(5, 4'b0001);
    chk_reg(2'd1, 16'h0015, "R2 tap0 five steps");
    ticks(3, 4'b1110);
    chk_reg(2'd1, 16'h0015, "R2 unselected taps");
    wr(2'd0, 16'h0002);
    ticks(3, 4'b0100);
    chk_reg(2'd1, 16'h0018, "R2 tap2 three steps");

    // R3 overflow reloads from latch
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hFFFD);
    ticks(3, 4'b0001);
    chk_reg(2'd1, 16'hFFFD, "R3 reload not wrap");
    chk_reg(2'd0, 16'h8000, "R3 flag set");
    push_exp(KIND_IRQ, 2'd0, 32'h0, "R7 irq masked");

    // R7 interrupt enable and write-one-to-clear
    wr(2'd0, 16'h0040);
    chk_reg(2'd0, 16'h8040, "R7 flag kept by zero write");
    push_exp(KIND_IRQ, 2'd0, 32'h1, "R7 irq raised");
    wr(2'd0, 16'h8040);
    chk_reg(2'd0, 16'h0040, "R7 flag cleared");
    push_exp(KIND_IRQ, 2'd0, 32'h0, "R7 irq dropped");

    // R5 edge-selected reload, three clock latency
    wr(2'd0, 16'h0004);
    wr(2'd1, 16'h0100);
    ticks(4, 4'b0001);
    load_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk_reg(2'd1, 16'h0104, "R5 not yet at edge two");
    @(negedge clk);
    chk_reg(2'd1, 16'h0100, "R5 rise reload at edge three");
    ticks(2, 4'b0001);
    load_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk_reg(2'd1, 16'h0102, "R5 fall ignored in rise mode");
    wr(2'd0, 16'h0008);
    load_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk_reg(2'd1, 16'h0102, "R5 rise ignored in fall mode");
    load_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk_reg(2'd1, 16'h0100, "R5 fall reload");
    wr(2'd0, 16'h000C);
    ticks(1, 4'b0001);
    load_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk_reg(2'd1, 16'h0100, "R5 both mode reload");
    wr(2'd0, 16'h0000);
    ticks(1, 4'b0001);
    load_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk_reg(2'd1, 16'h0101, "R5 disabled ignores edge");

    // R6 collisions
    wr(2'd0, 16'h000C);
    wr(2'd1, 16'hFFFE);
    ticks(1, 4'b0001);
    load_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    ticks(1, 4'b0001);
    chk_reg(2'd1, 16'hFFFE, "R6 edge plus overflow single reload");
    chk_reg(2'd0, 16'h800C, "R6 flag set on collision");
    load_pin = 1'b0;
    @(negedge clk);
    wr(2'd1, 16'h0A0A);
    chk_reg(2'd1, 16'h0A0A, "R6 write wins over edge");
    chk_reg(2'd2, 16'h0A0A, "R6 latch from write");

    // R8 time-base buses
    wr(2'd0, 16'h002C);
    push_exp(KIND_TBUS, 2'd0, 32'h0000_0A0A, "R8 bus0");
    wr(2'd0, 16'h0030);
    push_exp(KIND_TBUS, 2'd0, 32'h0A0A_0000, "R8 bus1");
    ticks(1, 4'b0001);
    push_exp(KIND_TBUS, 2'd0, 32'h0A0B_0000, "R8 bus1 follows count");
    wr(2'd0, 16'h0010);
    push_exp(KIND_TBUS, 2'd0, 32'h0, "R8 drive disabled");

    // R9 unused bits and reserved address
    wr(2'd0, 16'hFFFF);
    chk_reg(2'd0, 16'h007F, "R9 unused bits read zero");
    chk_reg(2'd3, 16'h0000, "R9 reserved address reads zero");
    wr(2'd2, 16'h5555);
    chk_reg(2'd2, 16'h0A0A, "R4 latch address write ignored");
    chk_reg(2'd1, 16'h0A0B, "R9 counter untouched");
    wr(2'd3, 16'h1234);
    chk_reg(2'd0, 16'h007F, "R9 reserved write ignored");

    wait (exp_q.size() == 0);
    #5;
    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule